// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer datapath slice of a processor core. It takes a source operand, a destination operand, an operation code, an operand size and the current five-bit condition flags. It returns the new destination value and the new flags. It covers these operations: add and subtract, including quick and extended forms; negate; compare; address-destination add and subtract; and bitwise AND, OR, XOR and NOT. It also performs clear, test, sign extension, half-word swap and test-and-set. Operands can be byte, word or long.

Each operation updates each flag by its own rule. A flag is either computed from the result, left as it was, forced to 0 or forced to 1. For this reason the extend flag often stays put while carry changes, and address-destination arithmetic touches no flag at all. At byte and word size only the low bits take part, and the upper bits of the destination pass through unchanged. The block registers the result and flags once per accepted strobe and raises a one-cycle completion pulse.

Top module: `int_alu_flags`

## Requirements
- R1: Opcodes 0 (add), 1 (subtract, dst minus src) and 4 (negate, zero minus dst) write the sized result. They set N from the sized sign bit, Z when the sized result is zero, V on signed overflow, and C on carry out or borrow, and they copy C into X. Flag bits are ordered X=bit 4, N=3, Z=2, V=1, C=0.
- R2: Opcodes 2 (add with extend), 3 (subtract with extend) and 5 (negate with extend) also add or subtract the incoming X. Their Z is cleared when the sized result is nonzero and keeps its incoming value otherwise. The other flags follow R1.
- R3: Opcodes 9 (quick add) and 10 (quick subtract) use src bits 2:0 as the immediate, with the value 0 standing for 8. Their flags follow R1.
- R4: Opcodes 7 (address add) and 8 (address subtract) operate on all 32 bits of dst and leave all five flags equal to the incoming flags. At word size the source is the sign-extended low 16 bits, and size code 00 is treated as word.
- R5: Opcode 6 (compare) outputs dst unchanged and keeps X. It sets N, Z, V and C from dst minus src at the selected size.
- R6: Opcodes 11 (AND), 12 (OR), 13 (XOR), 14 (NOT of dst), 16 (test: dst is returned unchanged) and 17 (sign extend) keep X, set N and Z from the sized result, and clear V and C. Sign extend widens byte to word at word size (and at size 00) and word to long at long size, with N and Z taken at the target size.
- R7: Opcode 15 (clear) zeroes the sized part of dst and gives N=0, Z=1, V=0 and C=0, with X kept.
- R8: Opcode 19 (test-and-set) ignores size. It sets N and Z from the original low byte, clears V and C, keeps X, and returns dst with bit 7 set.
- R9: Opcode 18 (swap) exchanges the 16-bit halves of dst. N and Z come from the full 32-bit result, V and C are cleared, and X is kept.
- R10: Size codes are 00 byte, 01 word, 10 long, and 11 is treated as long. At byte and word size the destination bits above the operand pass through unchanged, N comes from bit 7 or bit 15, and Z looks only at the low 8 or 16 bits.
- R11: Result and flags appear on the outputs one clock after a cycle with in_valid high, and done is high for exactly that cycle. Back-to-back strobes give back-to-back results. Without a strobe the outputs hold.
- R12: After reset, result, flags_out and done are all zero.
- R13: Any opcode above 19 returns dst unchanged and flags equal to flags_in, still with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are taken in this cycle |
| op | input | 5 | Operation code |
| size | input | 2 | Operand size select |
| src_a | input | 32 | Source operand |
| dst_b | input | 32 | Destination operand |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| result | output | 32 | Registered new destination value |
| flags_out | output | 5 | Registered new flags {X,N,Z,V,C} |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Two things can land in the same clock edge: the output register reports one operation's result while a fresh strobe loads the next operation into it. The bench provokes this by issuing runs of strobes on consecutive cycles that mix arithmetic, extended, address and logic codes, so every done pulse overlaps a new capture. A queue-based scoreboard takes one expected entry per strobe and pops one entry per done pulse. A done pulse with an empty queue, a swapped order or a missing result therefore shows up as a mismatch. Idle stretches with the inputs scrambled confirm that the outputs hold and that no extra pulse appears.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 32;
    localparam int NUM_SZ = 3;
    localparam int FLAG_W = 5;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_ADDX = 5'd2,
        OP_SUBX = 5'd3,
        OP_NEG  = 5'd4,
        OP_NEGX = 5'd5,
        OP_CMP  = 5'd6,
        OP_ADDA = 5'd7,
        OP_SUBA = 5'd8,
        OP_ADDQ = 5'd9,
        OP_SUBQ = 5'd10,
        OP_AND  = 5'd11,
        OP_OR   = 5'd12,
        OP_XOR  = 5'd13,
        OP_NOT  = 5'd14,
        OP_CLR  = 5'd15,
        OP_TST  = 5'd16,
        OP_EXT  = 5'd17,
        OP_SWAP = 5'd18,
        OP_TAS  = 5'd19
    } alu_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // size code 3 folds onto long
    function automatic logic [1:0] norm_sz(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

    function automatic logic [DATA_W-1:0] sz_mask(input logic [1:0] s);
        case (norm_sz(s))
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic sz_msb(input logic [DATA_W-1:0] val, input logic [1:0] s);
        case (norm_sz(s))
            2'd0:    return val[7];
            2'd1:    return val[15];
            default: return val[31];
        endcase
    endfunction

    function automatic logic sz_zero(input logic [DATA_W-1:0] val, input logic [1:0] s);
        return (val & sz_mask(s)) == '0;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              sub_i,
    input  logic              carry_i,
    input  logic [1:0]        sz_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              ovf_o
);

    logic [NUM_SZ-1:0] co_w;
    logic [NUM_SZ-1:0] ov_w;
    logic [DATA_W-1:0] part_w [NUM_SZ];
    logic              cin_eff;

    // subtract is dst + ~src + ~borrow_in
    assign cin_eff = sub_i ^ carry_i;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SZ; gi++) begin : g_width
            localparam int W = 8 << gi;
            logic [W-1:0] d_w;
            logic [W-1:0] s_w;
            logic [W:0]   t_w;

            assign d_w         = dst_i[W-1:0];
            assign s_w         = sub_i ? ~src_i[W-1:0] : src_i[W-1:0];
            assign t_w         = {1'b0, d_w} + {1'b0, s_w} + {{W{1'b0}}, cin_eff};
            assign part_w[gi]  = DATA_W'(t_w[W-1:0]);
            assign co_w[gi]    = t_w[W] ^ sub_i;
            assign ov_w[gi]    = (d_w[W-1] == s_w[W-1]) && (t_w[W-1] != d_w[W-1]);
        end
    endgenerate

    always_comb begin
        case (norm_sz(sz_i))
            2'd0: begin
                sum_o   = part_w[0];
                carry_o = co_w[0];
                ovf_o   = ov_w[0];
            end
            2'd1: begin
                sum_o   = part_w[1];
                carry_o = co_w[1];
                ovf_o   = ov_w[1];
            end
            default: begin
                sum_o   = part_w[2];
                carry_o = co_w[2];
                ovf_o   = ov_w[2];
            end
        endcase
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  alu_op_e           op_i,
    input  logic [1:0]        sz_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] tv_o,
    output logic [1:0]        tsz_o
);

    logic [DATA_W-1:0] m_w;

    assign m_w = sz_mask(sz_i);

    always_comb begin
        res_o = dst_i;
        tsz_o = norm_sz(sz_i);
        case (op_i)
            OP_AND:  res_o = (dst_i & ~m_w) | (dst_i & src_i & m_w);
            OP_OR:   res_o = (dst_i & ~m_w) | ((dst_i | src_i) & m_w);
            OP_XOR:  res_o = (dst_i & ~m_w) | ((dst_i ^ src_i) & m_w);
            OP_NOT:  res_o = (dst_i & ~m_w) | (~dst_i & m_w);
            OP_CLR:  res_o = dst_i & ~m_w;
            OP_TST:  res_o = dst_i;
            OP_EXT: begin
                if (norm_sz(sz_i) == 2'd2) begin
                    res_o = {{16{dst_i[15]}}, dst_i[15:0]};
                    tsz_o = 2'd2;
                end else begin
                    res_o = {dst_i[31:16], {8{dst_i[7]}}, dst_i[7:0]};
                    tsz_o = 2'd1;
                end
            end
            OP_SWAP: begin
                res_o = {dst_i[15:0], dst_i[31:16]};
                tsz_o = 2'd2;
            end
            OP_TAS: begin
                res_o = dst_i | 32'h0000_0080;
                tsz_o = 2'd0;
            end
            default: res_o = dst_i;
        endcase
        // test-and-set judges the operand before the write
        tv_o = (op_i == OP_TAS) ? dst_i : res_o;
    end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] dst_b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              done
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        ccr_t              flg;
        logic              done;
    } alu_state_t;

    alu_state_t st_d, st_q;

    alu_op_e           opc;
    ccr_t              fin;
    logic              is_neg, is_sub, is_ext, is_quick, is_arith, is_addr, is_logic;
    logic [DATA_W-1:0] quick_val, as_dst, as_src, sum_w, arith_res;
    logic              as_c, as_v;
    logic [DATA_W-1:0] addr_src, addr_res;
    logic [DATA_W-1:0] lu_res, lu_tv;
    logic [1:0]        lu_sz;

    assign opc      = alu_op_e'(op);
    assign fin      = ccr_t'(flags_in);

    assign is_neg   = (opc == OP_NEG)  || (opc == OP_NEGX);
    assign is_ext   = (opc == OP_ADDX) || (opc == OP_SUBX) || (opc == OP_NEGX);
    assign is_quick = (opc == OP_ADDQ) || (opc == OP_SUBQ);
    assign is_sub   = (opc == OP_SUB)  || (opc == OP_SUBX) || (opc == OP_SUBQ) ||
                      (opc == OP_CMP)  || is_neg;
    assign is_arith = (opc == OP_ADD)  || (opc == OP_ADDX) || (opc == OP_ADDQ) ||
                      (opc == OP_SUB)  || (opc == OP_SUBX) || (opc == OP_SUBQ) || is_neg;
    assign is_addr  = (opc == OP_ADDA) || (opc == OP_SUBA);
    assign is_logic = (opc == OP_AND)  || (opc == OP_OR)   || (opc == OP_XOR)  ||
                      (opc == OP_NOT)  || (opc == OP_CLR)  || (opc == OP_TST)  ||
                      (opc == OP_EXT)  || (opc == OP_SWAP) || (opc == OP_TAS);

    // quick immediate: 0 encodes 8
    assign quick_val = (src_a[2:0] == 3'd0) ? 32'd8 : {29'd0, src_a[2:0]};
    assign as_dst    = is_neg ? '0 : dst_b;
    assign as_src    = is_neg ? dst_b : (is_quick ? quick_val : src_a);

    alu_addsub u_addsub (
        .dst_i   (as_dst),
        .src_i   (as_src),
        .sub_i   (is_sub),
        .carry_i (is_ext & fin.x),
        .sz_i    (size),
        .sum_o   (sum_w),
        .carry_o (as_c),
        .ovf_o   (as_v)
    );

    assign arith_res = (dst_b & ~sz_mask(size)) | (sum_w & sz_mask(size));

    // address destination: full-width, word source sign-extended
    assign addr_src = (norm_sz(size) == 2'd2) ? src_a : {{16{src_a[15]}}, src_a[15:0]};
    assign addr_res = (opc == OP_SUBA) ? (dst_b - addr_src) : (dst_b + addr_src);

    alu_logic_unit u_logic (
        .dst_i (dst_b),
        .src_i (src_a),
        .op_i  (opc),
        .sz_i  (size),
        .res_o (lu_res),
        .tv_o  (lu_tv),
        .tsz_o (lu_sz)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = in_valid;
        if (in_valid) begin
            st_d.res = dst_b;
            st_d.flg = fin;
            if (is_arith || opc == OP_CMP) begin
                st_d.flg.n = sz_msb(sum_w, size);
                st_d.flg.z = is_ext ? (fin.z & sz_zero(sum_w, size)) : sz_zero(sum_w, size);
                st_d.flg.v = as_v;
                st_d.flg.c = as_c;
                if (is_arith) begin
                    st_d.res   = arith_res;
                    st_d.flg.x = as_c;
                end
            end else if (is_addr) begin
                st_d.res = addr_res;
            end else if (is_logic) begin
                st_d.res   = lu_res;
                st_d.flg.n = sz_msb(lu_tv, lu_sz);
                st_d.flg.z = sz_zero(lu_tv, lu_sz);
                st_d.flg.v = 1'b0;
                st_d.flg.c = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign flags_out = st_q.flg;
    assign done      = st_q.done;

    // ---- checks on the output register ----
    assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags_out)));

    assert_addr_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_addr) |=> (flags_out == $past(flags_in)));

    assert_logic_vc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_logic) |=> (flags_out[1:0] == 2'b00));

    assert_clr_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == OP_CLR) |=>
            (flags_out[3:2] == 2'b01 && flags_out[4] == $past(flags_in[4])));

    assert_tas_bit7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == OP_TAS) |=> result[7]);

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == OP_CMP) |=>
            (result == $past(dst_b) && flags_out[4] == $past(flags_in[4])));

    assert_byte_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_arith && norm_sz(size) == 2'd0) |=>
            (result[31:8] == $past(dst_b[31:8])));

endmodule

// File: tb/int_alu_flags_tb_top.sv
`timescale 1ns/100ps
module int_alu_flags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] src_a = '0;
    logic [31:0] dst_b = '0;
    logic [4:0]  flags_in = '0;
    logic [31:0] result;
    logic [4:0]  flags_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] q_res [$];
    logic [4:0]  q_flg [$];
    string       q_tag [$];
    logic [31:0] last_res;
    logic [4:0]  last_flg;

    always #2.5 clk = ~clk;

    int_alu_flags dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .src_a(src_a), .dst_b(dst_b), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .done(done)
    );

    function automatic logic [36:0] model(input logic [4:0] o, input logic [1:0] s,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [4:0] f);
        longint unsigned m, sb, da, sa, res, brw;
        logic [1:0] ns;
        logic x, n, z, v, c, zr, ng, ex;
        logic [31:0] r, sx;
        ns = (s == 2'd3) ? 2'd2 : s;
        m  = (ns == 0) ? 64'hFF : (ns == 1) ? 64'hFFFF : 64'hFFFF_FFFF;
        sb = (m + 1) >> 1;
        {x, n, z, v, c} = f;
        r = b;
        case (o)
            5'd0, 5'd2, 5'd9: begin
                da  = b & m;
                sa  = (o == 9) ? ((a[2:0] == 0) ? 64'd8 : longint'(a[2:0])) : (a & m);
                brw = (o == 2) ? longint'(f[4]) : 0;
                res = da + sa + brw;
                c   = res > m;
                res = res & m;
                v   = ((da & sb) == (sa & sb)) && ((res & sb) != (da & sb));
                n   = (res & sb) != 0;
                zr  = res == 0;
                z   = (o == 2) ? (z & zr) : zr;
                x   = c;
                r   = 32'((b & ~m) | res);
            end
            5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd10: begin
                ng  = (o == 4) || (o == 5);
                ex  = (o == 3) || (o == 5);
                da  = ng ? 0 : (b & m);
                sa  = (o == 10) ? ((a[2:0] == 0) ? 64'd8 : longint'(a[2:0])) : ng ? (b & m) : (a & m);
                brw = ex ? longint'(f[4]) : 0;
                c   = (sa + brw) > da;
                res = (da - sa - brw) & m;
                v   = ((da & sb) != (sa & sb)) && ((res & sb) != (da & sb));
                n   = (res & sb) != 0;
                zr  = res == 0;
                z   = ex ? (z & zr) : zr;
                if (o != 6) begin
                    x = c;
                    r = 32'((b & ~m) | res);
                end
            end
            5'd7, 5'd8: begin
                sx = (ns == 2) ? a : {{16{a[15]}}, a[15:0]};
                r  = (o == 7) ? b + sx : b - sx;
            end
            5'd11, 5'd12, 5'd13, 5'd14, 5'd15, 5'd16: begin
                case (o)
                    5'd11:   res = (b & a) & m;
                    5'd12:   res = (b | a) & m;
                    5'd13:   res = (b ^ a) & m;
                    5'd14:   res = (~b) & m;
                    5'd15:   res = 0;
                    default: res = b & m;
                endcase
                r = (o == 16) ? b : 32'((b & ~m) | res);
                n = (res & sb) != 0;
                z = res == 0;
                v = 0; c = 0;
            end
            5'd17: begin
                if (ns == 2) begin
                    r = {{16{b[15]}}, b[15:0]}; n = r[31]; z = (r == 0);
                end else begin
                    r = {b[31:16], {8{b[7]}}, b[7:0]}; n = r[15]; z = (r[15:0] == 0);
                end
                v = 0; c = 0;
            end
            5'd18: begin
                r = {b[15:0], b[31:16]}; n = r[31]; z = (r == 0); v = 0; c = 0;
            end
            5'd19: begin
                n = b[7]; z = (b[7:0] == 0); r = b | 32'h80; v = 0; c = 0;
            end
            default: ;
        endcase
        return {r, x, n, z, v, c};
    endfunction

    task automatic send(input logic [4:0] o, input logic [1:0] s, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] f, input string tag);
        logic [36:0] e;
        @(negedge clk);
        in_valid = 1'b1; op = o; size = s; src_a = a; dst_b = b; flags_in = f;
        e = model(o, s, a, b, f);
        q_res.push_back(e[36:5]);
        q_flg.push_back(e[4:0]);
        q_tag.push_back(tag);
        last_res = e[36:5];
        last_flg = e[4:0];
    endtask

    // idle with scrambled inputs: outputs must hold, no pulse (R11)
    task automatic idle_hold(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; op = 5'(i + 3); src_a = 32'hDEAD_0000 + i; dst_b = ~dst_b; flags_in = ~flags_in;
            if (i > 0) begin
                checks++;
                if (done !== 1'b0 || result !== last_res || flags_out !== last_flg) begin
                    errors++;
                    $display("FAIL R11 hold: done=%0b res=%h flg=%b exp res=%h flg=%b",
                             done, result, flags_out, last_res, last_flg);
                end
            end
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && done === 1'b1) begin
                checks++;
                if (q_res.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected done: res=%h flg=%b exp none", result, flags_out);
                end else begin
                    logic [31:0] er;
                    logic [4:0]  ef;
                    string       et;
                    er = q_res.pop_front();
                    ef = q_flg.pop_front();
                    et = q_tag.pop_front();
                    if (result !== er || flags_out !== ef) begin
                        errors++;
                        $display("FAIL %s: res=%h flg=%b exp res=%h flg=%b", et, result, flags_out, er, ef);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (result !== 32'h0 || flags_out !== 5'h0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: res=%h flg=%b done=%b exp 0 0 0", result, flags_out, done);
        end
        rst_n = 1'b1;
        idle_hold(1);

        // R1 add/sub/neg
        send(5'd0, 2'd2, 32'h0000_0001, 32'h7FFF_FFFF, 5'b00000, "R1 add long overflow");
        send(5'd0, 2'd0, 32'h0000_0001, 32'hAABB_CCFF, 5'b00010, "R1 R10 add byte carry");
        send(5'd0, 2'd1, 32'h0000_8000, 32'h1234_8000, 5'b00000, "R1 R10 add word V C Z");
        send(5'd1, 2'd2, 32'h0000_0001, 32'h0000_0000, 5'b00000, "R1 sub borrow");
        send(5'd1, 2'd0, 32'h0000_0001, 32'h5555_5580, 5'b10000, "R1 R10 sub byte V");
        send(5'd4, 2'd0, 32'h0, 32'hFFFF_FF80, 5'b00000, "R1 neg byte 0x80");
        send(5'd4, 2'd1, 32'h0, 32'h0001_0000, 5'b11111, "R1 neg zero");
        send(5'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 5'b00000, "R10 size 11 as long");
        idle_hold(3);

        // R2 extended
        send(5'd2, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 5'b10100, "R2 addx zero keeps Z");
        send(5'd2, 2'd2, 32'h0000_0001, 32'h0000_0001, 5'b10100, "R2 addx nonzero clears Z");
        send(5'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 5'b00000, "R2 addx zero Z stays 0");
        send(5'd3, 2'd1, 32'h0000_0001, 32'h0000_0002, 5'b10100, "R2 subx to zero");
        send(5'd3, 2'd2, 32'h0000_0000, 32'h0000_0000, 5'b10100, "R2 subx borrow");
        send(5'd5, 2'd0, 32'h0, 32'h0000_0000, 5'b10100, "R2 negx of zero with X");
        send(5'd5, 2'd2, 32'h0, 32'h0000_0000, 5'b00100, "R2 negx zero no X");

        // R3 quick
        send(5'd9, 2'd2, 32'h0000_0000, 32'h0000_0010, 5'b00000, "R3 addq 0 means 8");
        send(5'd9, 2'd0, 32'hFFFF_FFFB, 32'h0000_00FE, 5'b00000, "R3 addq 3 byte");
        send(5'd10, 2'd0, 32'h0000_0008, 32'h0000_0005, 5'b00000, "R3 subq 0 means 8");

        // R4 address
        send(5'd7, 2'd1, 32'h0000_FFFF, 32'h0000_1000, 5'b01011, "R4 adda word sext");
        send(5'd8, 2'd2, 32'h0000_0010, 32'h0000_0000, 5'b10101, "R4 suba long");
        send(5'd7, 2'd0, 32'h1234_8000, 32'h0001_0000, 5'b11111, "R4 adda size 00 as word");

        // R5 compare
        send(5'd6, 2'd2, 32'h0000_0005, 32'h0000_0005, 5'b10000, "R5 cmp equal");
        send(5'd6, 2'd1, 32'h0000_0007, 32'hABCD_0003, 5'b00000, "R5 cmp less");
        send(5'd6, 2'd0, 32'h0000_0001, 32'h0000_0080, 5'b10000, "R5 cmp byte overflow");
        idle_hold(2);

        // R6 logic
        send(5'd11, 2'd0, 32'h0000_00F0, 32'h1111_1180, 5'b10011, "R6 and byte");
        send(5'd12, 2'd1, 32'h0000_8000, 32'h2222_0001, 5'b00011, "R6 or word");
        send(5'd13, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b10011, "R6 xor long zero");
        send(5'd14, 2'd1, 32'h0, 32'h3333_FFFF, 5'b11111, "R6 not word");
        send(5'd16, 2'd2, 32'h0, 32'h8000_0000, 5'b00011, "R6 tst negative");
        send(5'd17, 2'd1, 32'h0, 32'hAAAA_1280, 5'b10011, "R6 ext byte to word");
        send(5'd17, 2'd2, 32'h0, 32'h5555_0000, 5'b00011, "R6 ext word to long zero");
        send(5'd17, 2'd0, 32'h0, 32'h0000_007F, 5'b00000, "R6 ext size 00 as word");

        // R7 clr, R8 tas, R9 swap
        send(5'd15, 2'd1, 32'h0, 32'hCAFE_BABE, 5'b11011, "R7 clr word");
        send(5'd15, 2'd2, 32'h0, 32'hCAFE_BABE, 5'b01011, "R7 clr long");
        send(5'd19, 2'd2, 32'h0, 32'h1234_5600, 5'b00011, "R8 tas zero byte");
        send(5'd19, 2'd0, 32'h0, 32'h0000_0081, 5'b10000, "R8 tas negative");
        send(5'd18, 2'd0, 32'h0, 32'h0000_8001, 5'b10011, "R9 swap");
        send(5'd18, 2'd2, 32'h0, 32'h0000_0000, 5'b00000, "R9 swap zero");

        // R13 undefined codes
        send(5'd20, 2'd2, 32'h1, 32'h0BAD_F00D, 5'b10101, "R13 undefined 20");
        send(5'd31, 2'd0, 32'h1, 32'h1357_9BDF, 5'b01010, "R13 undefined 31");
        idle_hold(4);

        repeat (3) @(negedge clk);
        checks++;
        if (q_res.size() != 0) begin
            errors++;
            $display("FAIL R11 missing results: left=%0d exp 0", q_res.size());
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule